// File: doc/BRIEF.md
# Load-Use Stall and Branch Flush Controller

This block decides, every cycle, whether a five-stage in-order pipeline may advance normally, must hold for one cycle because a load's result is needed too early, or must discard a wrongly fetched instruction because a branch resolved as taken. It compares the source register indices of the instruction in decode with the destination of the instruction in execute. When that execute instruction reads memory, its value cannot be forwarded in time, so the block freezes the program counter and the fetch/decode register and turns the instruction entering execute into a bubble.

Branches are assumed not taken. When the execute stage reports a taken branch, the block clears the fetch/decode register and the control bits entering execute. A taken branch takes priority over a load-use hold in the same cycle. A hold never lasts more than one cycle, and register 0 never causes one.

Top module: `hazard_ctl`

## Requirements
- R1: After reset is released, with no load in execute and no taken branch, the outputs show free flow: pc_we=1, ifid_we=1, ex_bubble=0, ifid_flush=0.
- R2: When ex_mem_rd=1, ex_dst is nonzero, id_use_a=1 and id_src_a equals ex_dst, and no branch is taken, the block holds: pc_we=0, ifid_we=0, ex_bubble=1, ifid_flush=0.
- R3: The same hold occurs when the match is on source B (id_use_b=1 and id_src_b equals ex_dst). It also occurs when both sources match.
- R4: A source whose use flag is 0 never causes a hold, even when its index matches.
- R5: When ex_mem_rd=0, no hold occurs, whatever the indices are.
- R6: A destination index of 0 never causes a hold.
- R7: A hold lasts exactly one cycle. In the cycle after a hold, pc_we and ifid_we are 1 even if the hazard inputs still match.
- R8: When br_taken=1, the outputs are pc_we=1, ifid_we=1, ifid_flush=1 and ex_bubble=1.
- R9: When br_taken=1 and a load-use match occur in the same cycle, the flush outputs of R8 appear and no hold occurs.
- R10: A load-use match that was overridden by a flush does not count as a hold. If the match is still present in the next cycle with no branch, the hold of R2 occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_src_a | input | IDX_W | First source index of the decode instruction |
| id_use_a | input | 1 | First source is read by the decode instruction |
| id_src_b | input | IDX_W | Second source index of the decode instruction |
| id_use_b | input | 1 | Second source is read by the decode instruction |
| ex_dst | input | IDX_W | Destination index of the execute instruction |
| ex_mem_rd | input | 1 | Execute instruction is a memory load |
| br_taken | input | 1 | Branch in execute resolved as taken |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ex_bubble | output | 1 | Zero the control bits entering execute |
| ifid_flush | output | 1 | Clear the fetch/decode register |

## Verification
The load-use hold and the taken-branch flush can both be requested in one cycle. The bench provokes this by raising br_taken while a load in execute matches source A. The result passes only if pc_we and ifid_we stay high while ifid_flush and ex_bubble rise. The bench then keeps the same match for one more cycle without the branch. It expects a real hold there, which shows that the hold suppressed by the flush was not counted against the one-cycle limit.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic ex_bubble;
    logic ifid_flush;
  } hzd_ctl_t;

  localparam hzd_ctl_t CTL_FLOW  = '{pc_we: 1'b1, ifid_we: 1'b1, ex_bubble: 1'b0, ifid_flush: 1'b0};
  localparam hzd_ctl_t CTL_HOLD  = '{pc_we: 1'b0, ifid_we: 1'b0, ex_bubble: 1'b1, ifid_flush: 1'b0};
  localparam hzd_ctl_t CTL_FLUSH = '{pc_we: 1'b1, ifid_we: 1'b1, ex_bubble: 1'b1, ifid_flush: 1'b1};

endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][IDX_W-1:0] src_idx,
  input  logic [NUM_SRC-1:0]            src_used,
  input  logic [IDX_W-1:0]              dst_idx,
  input  logic                          dst_is_load,
  output logic                          load_hit
);

  logic [NUM_SRC-1:0] per_src_hit;
  logic               dst_live;

  // Register 0 is hardwired, so it never carries a pending value.
  assign dst_live = dst_is_load && (dst_idx != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign per_src_hit[g] = src_used[g] && (src_idx[g] == dst_idx);
  end

  assign load_hit = dst_live && (|per_src_hit);

endmodule

// File: rtl/hzd_arbiter.sv
module hzd_arbiter
  import hzd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_hit,
  input  logic     br_taken,
  output hzd_ctl_t ctl
);

  logic held_q;
  logic held_d;
  logic hold_now;

  // Flush outranks hold; a hold directly after a hold is refused.
  always_comb begin
    hold_now = load_hit && !br_taken && !held_q;
    held_d   = hold_now;
    if (br_taken) begin
      ctl = CTL_FLUSH;
    end else if (hold_now) begin
      ctl = CTL_HOLD;
    end else begin
      ctl = CTL_FLOW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else begin
      held_q <= held_d;
    end
  end

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hzd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] id_src_a,
  input  logic             id_use_a,
  input  logic [IDX_W-1:0] id_src_b,
  input  logic             id_use_b,
  input  logic [IDX_W-1:0] ex_dst,
  input  logic             ex_mem_rd,
  input  logic             br_taken,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             ex_bubble,
  output logic             ifid_flush
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][IDX_W-1:0] src_vec;
  logic [NUM_SRC-1:0]            use_vec;
  logic                          load_hit;
  hzd_ctl_t                      ctl;

  assign src_vec = {id_src_b, id_src_a};
  assign use_vec = {id_use_b, id_use_a};

  hzd_src_match #(
    .IDX_W  (IDX_W),
    .NUM_SRC(NUM_SRC)
  ) i_match (
    .src_idx    (src_vec),
    .src_used   (use_vec),
    .dst_idx    (ex_dst),
    .dst_is_load(ex_mem_rd),
    .load_hit   (load_hit)
  );

  hzd_arbiter i_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_hit(load_hit),
    .br_taken(br_taken),
    .ctl     (ctl)
  );

  assign pc_we      = ctl.pc_we;
  assign ifid_we    = ctl.ifid_we;
  assign ex_bubble  = ctl.ex_bubble;
  assign ifid_flush = ctl.ifid_flush;

endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] id_src_a,
  input logic             id_use_a,
  input logic [IDX_W-1:0] ex_dst,
  input logic             ex_mem_rd,
  input logic             br_taken,
  input logic             pc_we,
  input logic             ifid_we,
  input logic             ex_bubble,
  input logic             ifid_flush
);

  logic prev_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hold <= 1'b0;
    end else begin
      prev_hold <= !pc_we;
    end
  end

  // R2 / R3: the PC and the fetch/decode register always freeze together.
  p_freeze_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we == ifid_we);

  p_hit_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_rd && ex_dst != '0 && id_use_a && id_src_a == ex_dst && !br_taken && !prev_hold)
      |-> (!pc_we && ex_bubble && !ifid_flush));

  p_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_mem_rd |-> pc_we);

  p_zero_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> pc_we);

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prev_hold |-> pc_we);

  p_flush_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (pc_we && ifid_we && ifid_flush && ex_bubble));

endmodule

bind hazard_ctl hazard_ctl_chk #(.IDX_W(IDX_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .id_src_a  (id_src_a),
  .id_use_a  (id_use_a),
  .ex_dst    (ex_dst),
  .ex_mem_rd (ex_mem_rd),
  .br_taken  (br_taken),
  .pc_we     (pc_we),
  .ifid_we   (ifid_we),
  .ex_bubble (ex_bubble),
  .ifid_flush(ifid_flush)
);

// File: tb/test_hazard_ctl.sv
module test_hazard_ctl;

  localparam int IDX_W = 5;

  logic             clk;
  logic             rst_n;
  logic [IDX_W-1:0] id_src_a;
  logic             id_use_a;
  logic [IDX_W-1:0] id_src_b;
  logic             id_use_b;
  logic [IDX_W-1:0] ex_dst;
  logic             ex_mem_rd;
  logic             br_taken;
  logic             pc_we;
  logic             ifid_we;
  logic             ex_bubble;
  logic             ifid_flush;

  typedef struct {
    logic [3:0] ctl;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks;
  int   n_fail;
  bit   done;

  hazard_ctl #(.IDX_W(IDX_W)) i_hazard_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_src_a  (id_src_a),
    .id_use_a  (id_use_a),
    .id_src_b  (id_src_b),
    .id_use_b  (id_use_b),
    .ex_dst    (ex_dst),
    .ex_mem_rd (ex_mem_rd),
    .br_taken  (br_taken),
    .pc_we     (pc_we),
    .ifid_we   (ifid_we),
    .ex_bubble (ex_bubble),
    .ifid_flush(ifid_flush)
  );

  // 125 MHz clock.
  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Expected encodings {pc_we, ifid_we, ex_bubble, ifid_flush}.
  localparam logic [3:0] FLOW  = 4'b1100;
  localparam logic [3:0] HOLD  = 4'b0010;
  localparam logic [3:0] FLUSH = 4'b1111;

  task automatic step(input logic [IDX_W-1:0] sa, input logic ua,
                      input logic [IDX_W-1:0] sb, input logic ub,
                      input logic [IDX_W-1:0] d, input logic mr, input logic bt,
                      input logic [3:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    id_src_a = sa; id_use_a = ua; id_src_b = sb; id_use_b = ub;
    ex_dst = d; ex_mem_rd = mr; br_taken = bt;
    it.ctl = e;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: compare between edges, after the driver has settled the inputs.
  always @(negedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      exp_t it;
      logic [3:0] got;
      it  = exp_q.pop_front();
      got = {pc_we, ifid_we, ex_bubble, ifid_flush};
      n_checks++;
      if (got !== it.ctl) begin
        n_fail++;
        $display("FAIL %s: got %b expected %b", it.tag, got, it.ctl);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    id_src_a = '0; id_use_a = 1'b0; id_src_b = '0; id_use_b = 1'b0;
    ex_dst = '0; ex_mem_rd = 1'b0; br_taken = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    step(5'd0, 0, 5'd0, 0, 5'd0, 0, 0, FLOW,  "R1 idle after reset");
    step(5'd5, 1, 5'd9, 1, 5'd5, 1, 0, HOLD,  "R2 load hit on source A");
    step(5'd5, 1, 5'd9, 1, 5'd5, 1, 0, FLOW,  "R7 no second hold cycle");
    step(5'd3, 1, 5'd7, 1, 5'd7, 1, 0, HOLD,  "R3 load hit on source B");
    step(5'd0, 0, 5'd0, 0, 5'd0, 0, 0, FLOW,  "R3 release to flow");
    step(5'd6, 0, 5'd1, 1, 5'd6, 1, 0, FLOW,  "R4 unused source ignored");
    step(5'd6, 1, 5'd6, 1, 5'd6, 0, 0, FLOW,  "R5 non-load ignored");
    step(5'd0, 1, 5'd0, 1, 5'd0, 1, 0, FLOW,  "R6 register zero ignored");
    step(5'd2, 1, 5'd4, 1, 5'd8, 0, 1, FLUSH, "R8 taken branch flushes");
    step(5'd5, 1, 5'd9, 1, 5'd5, 1, 1, FLUSH, "R9 flush wins over hold");
    step(5'd5, 1, 5'd9, 1, 5'd5, 1, 0, HOLD,  "R10 hold after overridden hit");
    step(5'd5, 1, 5'd9, 1, 5'd5, 1, 0, FLOW,  "R7 hold ends after one cycle");
    step(5'd0, 0, 5'd0, 0, 5'd0, 0, 0, FLOW,  "R7 idle gap");
    step(5'd11, 1, 5'd11, 1, 5'd11, 1, 0, HOLD, "R3 both sources match");
    step(5'd0, 0, 5'd0, 0, 5'd0, 0, 0, FLOW,  "R1 final flow");

    @(negedge clk);
    #5;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule